// File: doc/BRIEF.md
# Configurable UART frame receiver

This block turns an asynchronous serial line into received characters. The frame format is set at run time by a group of mode inputs: the data length (5 to 8 bits), an optional parity bit of one of four types, an optional extra bit after the data, one or long stop bits, and an addressed multiprocessor mode. In that mode only frames whose extra bit is 1 complete a reception. A free-running tick at 16 times the bit rate paces the receiver. The block finds the falling start edge, confirms the start bit at its centre, and samples every later bit at its centre. Bits arrive least significant first, in this order: start, data, parity, extra, stop.

At the end of a frame the receiver loads the data word and the extra bit. It also raises a sticky receive-complete flag, a parity-error flag and a framing-error flag. All three flags stay set until a clear strobe arrives. The mode is captured when a start bit is detected, so it cannot change in the middle of a frame.

The frame state machine has seven states.
- IDLE: waits for a low line on a tick, then goes to START.
- START: at the half-bit point it goes back to IDLE if the line has returned high, and goes to DATA otherwise.
- DATA: after the last data bit it goes to PARITY, EXTRA or STOP1, depending on the mode.
- PARITY: goes to EXTRA or STOP1.
- EXTRA: goes to STOP1.
- STOP1: goes to STOP2 when long stop is selected, otherwise back to IDLE (frame end).
- STOP2: goes to IDLE (frame end). Its sample point is a full bit after STOP1, or three quarters of a bit after it for 5-bit data.

Top module: `uart_frame_rx`

## Requirements
- R1: `len_sel` 00/01/10/11 selects 5/6/7/8 data bits. The bits are received least significant first into `data_out[0]` upward, and the unused upper bits of `data_out` read 0.
- R2: A low pulse shorter than half a bit period is treated as noise. The receiver returns to idle, and no output or flag changes.
- R3: With `par_en`=1 a parity bit follows the data. `par_type` 00 = odd (data plus parity hold an odd number of ones), 01 = even, 10 = parity bit must be 1, 11 = parity bit must be 0. A mismatch sets `par_err` at frame end.
- R4: With `par_en`=0 no parity bit is in the frame and `par_err` is never set.
- R5: With `xbit_en`=1 one extra bit follows the parity bit (or the data when parity is off). Its value appears on `xbit_out` when the frame completes. With `xbit_en`=0, `xbit_out` loads 0.
- R6: `stop_long`=0 gives one stop bit. `stop_long`=1 gives two stop bits for 6 to 8 data bits and 1.5 for 5 data bits. A 0 sampled in any stop position sets `frm_err`.
- R7: With `mp_en`=0, `rx_done` is set at frame end when every stop bit sampled 1.
- R8: With `mp_en`=1 (`xbit_en` must be 1), `rx_done` is set only when the stop bits and the extra bit are all 1.
- R9: `data_out` and `xbit_out` load only at a frame end that sets `rx_done`. Otherwise they keep their values.
- R10: `rx_done`, `par_err` and `frm_err` stay set until `flag_clr` is high for a cycle. The clear wins over a set in the same cycle.
- R11: After reset every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data length select |
| par_en | input | 1 | Parity bit present and checked |
| par_type | input | 2 | Parity type select |
| xbit_en | input | 1 | Extra bit present |
| stop_long | input | 1 | Long stop setting |
| mp_en | input | 1 | Multiprocessor address mode |
| flag_clr | input | 1 | Clears the three flags |
| data_out | output | 8 | Last accepted data word |
| xbit_out | output | 1 | Last accepted extra bit |
| rx_done | output | 1 | Sticky receive-complete flag |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and a two-stage line synchronizer. It drives one tick every four clocks, which leaves several ticks of margin around each centre sample. With these values the bench can reach every data length and every parity type. It also covers both long-stop timings, including the three-quarter-bit sample of the half stop bit, and framing errors in the first and second stop positions. Further cases are a short noise pulse and the suppressed and accepted cases of the multiprocessor mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_EXTRA,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    // run-time frame format, captured at start-bit detection
    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic [1:0] par_type;
        logic       xb_en;
        logic       stop_long;
        logic       mp_en;
    } rx_cfg_t;

    localparam logic [1:0] PAR_ODD   = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_MARK  = 2'b10;
    localparam logic [1:0] PAR_SPACE = 2'b11;

    // value the parity bit must carry; unused data bits are zero
    function automatic logic want_parity(input logic [DATA_W-1:0] d,
                                         input logic [1:0] kind);
        logic r;
        unique case (kind)
            PAR_ODD:   r = ~(^d);
            PAR_EVEN:  r = ^d;
            PAR_MARK:  r = 1'b1;
            PAR_SPACE: r = 1'b0;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] target,
    output logic          hit
);
    logic [CW-1:0] cnt;

    // counts ticks since the last load or hit; wraps on hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= '0;
        else if (tick) begin
            if (cnt == target) cnt <= '0;
            else               cnt <= cnt + 1'b1;
        end
    end

    assign hit = tick && !load && (cnt == target);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  rx_cfg_t           cfg_in,
    input  logic              hit,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_target,
    output rx_state_t         state_o,
    output rx_cfg_t           cfg_o,
    output logic              fin,
    output logic              stop_ok,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bit,
    output logic              xb_bit
);
    localparam logic [CW-1:0] T_HALF = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] T_FULL = CW'(OSR - 1);
    localparam logic [CW-1:0] T_3Q   = CW'(OSR/2 + OSR/4 - 1);
    localparam int IW = $clog2(DATA_W);

    rx_state_t         state, nxt;
    rx_cfg_t           cfg_r;
    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last_idx;
    logic              par_r, xb_r, stop1_r;

    assign last_idx = IW'(cfg_r.len) + IW'(4);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  if (hit) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (hit && idx == last_idx) begin
                           if (cfg_r.par_en)     nxt = ST_PARITY;
                           else if (cfg_r.xb_en) nxt = ST_EXTRA;
                           else                  nxt = ST_STOP1;
                       end
            ST_PARITY: if (hit) nxt = cfg_r.xb_en ? ST_EXTRA : ST_STOP1;
            ST_EXTRA:  if (hit) nxt = ST_STOP1;
            ST_STOP1:  if (hit) nxt = cfg_r.stop_long ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (hit) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs of the machine: timer control and frame-end strobe
    always_comb begin
        tmr_load   = 1'b0;
        tmr_target = T_FULL;
        fin        = 1'b0;
        stop_ok    = line;
        unique case (state)
            ST_IDLE:   tmr_load = 1'b1;
            ST_START:  tmr_target = T_HALF;
            ST_DATA,
            ST_PARITY,
            ST_EXTRA:  tmr_target = T_FULL;
            ST_STOP1:  fin = hit && !cfg_r.stop_long;
            ST_STOP2: begin
                tmr_target = (cfg_r.len == 2'b00) ? T_3Q : T_FULL;
                fin        = hit;
                stop_ok    = stop1_r & line;
            end
            default:   tmr_load = 1'b1;
        endcase
    end

    // bit capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r   <= '0;
            shreg   <= '0;
            idx     <= '0;
            par_r   <= 1'b0;
            xb_r    <= 1'b0;
            stop1_r <= 1'b0;
        end else if (state == ST_IDLE && nxt == ST_START) begin
            cfg_r <= cfg_in;
            shreg <= '0;
            idx   <= '0;
            par_r <= 1'b0;
            xb_r  <= 1'b0;
        end else if (hit) begin
            unique case (state)
                ST_DATA: begin
                    shreg[idx] <= line;
                    idx        <= idx + 1'b1;
                end
                ST_PARITY: par_r   <= line;
                ST_EXTRA:  xb_r    <= line;
                ST_STOP1:  stop1_r <= line;
                default: ;
            endcase
        end
    end

    assign state_o = state;
    assign cfg_o   = cfg_r;
    assign data_o  = shreg;
    assign par_bit = par_r;
    assign xb_bit  = xb_r;
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_bit,
    input  logic              xb_bit,
    input  rx_cfg_t           cfg,
    input  logic              flag_clr,
    output logic              ld,
    output logic [DATA_W-1:0] data_out,
    output logic              xbit_out,
    output logic              rx_done,
    output logic              par_err,
    output logic              frm_err
);
    logic perr_set, ferr_set;

    assign ld       = fin && stop_ok && (!cfg.mp_en || xb_bit);
    assign perr_set = fin && cfg.par_en && (par_bit != want_parity(data_in, cfg.par_type));
    assign ferr_set = fin && !stop_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            xbit_out <= 1'b0;
        end else if (ld) begin
            data_out <= data_in;
            xbit_out <= xb_bit;
        end
    end

    // sticky flags, clear dominant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_done <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else if (flag_clr) begin
            rx_done <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            rx_done <= rx_done | ld;
            par_err <= par_err | perr_set;
            frm_err <= frm_err | ferr_set;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic [1:0]        par_type,
    input  logic              xbit_en,
    input  logic              stop_long,
    input  logic              mp_en,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] data_out,
    output logic              xbit_out,
    output logic              rx_done,
    output logic              par_err,
    output logic              frm_err
);
    logic              line_s;
    logic              hit_w, load_w, fin_w, stop_ok_w, par_w, xb_w, ld_w;
    logic [CW-1:0]     target_w;
    logic [DATA_W-1:0] shdata_w;
    rx_state_t         state_w;
    rx_cfg_t           cfg_now, cfg_w;

    assign cfg_now = '{len: len_sel, par_en: par_en, par_type: par_type,
                       xb_en: xbit_en, stop_long: stop_long, mp_en: mp_en};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    rx_bit_timer #(.OSR(OSR)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .load(load_w),
        .target(target_w), .hit(hit_w)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .cfg_in(cfg_now), .hit(hit_w), .tmr_load(load_w),
        .tmr_target(target_w), .state_o(state_w), .cfg_o(cfg_w),
        .fin(fin_w), .stop_ok(stop_ok_w), .data_o(shdata_w),
        .par_bit(par_w), .xb_bit(xb_w)
    );

    rx_result_reg u_res (
        .clk(clk), .rst_n(rst_n), .fin(fin_w), .stop_ok(stop_ok_w),
        .data_in(shdata_w), .par_bit(par_w), .xb_bit(xb_w), .cfg(cfg_w),
        .flag_clr(flag_clr), .ld(ld_w), .data_out(data_out),
        .xbit_out(xbit_out), .rx_done(rx_done), .par_err(par_err),
        .frm_err(frm_err)
    );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flag_clr,
    input logic              rx_done,
    input logic              frm_err,
    input logic              par_err,
    input logic [DATA_W-1:0] data_out,
    input logic              xbit_out,
    input logic              ld,
    input logic              mp_cfg,
    input rx_state_t         state
);
    // R10
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err && !flag_clr |=> frm_err);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !rx_done && !par_err && !frm_err);

    // R9
    data_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> $past(ld));

    // R8
    mp_extra_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld && mp_cfg |=> xbit_out);

    // R7
    done_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(state == ST_STOP1 || state == ST_STOP2));
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .rx_done(rx_done),
    .frm_err(frm_err), .par_err(par_err), .data_out(data_out),
    .xbit_out(xbit_out), .ld(ld_w), .mp_cfg(cfg_w.mp_en), .state(state_w)
);

// File: tb/tb_uart_frame_rx.sv
module tb_uart_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int OSR = 16;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic [1:0] len_sel = 2'b11;
    logic par_en = 1'b0;
    logic [1:0] par_type = 2'b00;
    logic xbit_en = 1'b0;
    logic stop_long = 1'b0;
    logic mp_en = 1'b0;
    logic flag_clr = 1'b0;
    logic os_tick;
    logic [7:0] data_out;
    logic xbit_out, rx_done, par_err, frm_err;

    int checks = 0;
    int failures = 0;
    bit mon_busy = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic last_xb = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       xb;
        logic       done;
        logic       perr;
        logic       ferr;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    int tdiv;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tdiv <= 0;
        else        tdiv <= (tdiv == TDIV-1) ? 0 : tdiv + 1;
    end
    assign os_tick = (tdiv == TDIV-1);

    uart_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_type(par_type),
        .xbit_en(xbit_en), .stop_long(stop_long), .mp_en(mp_en),
        .flag_clr(flag_clr), .data_out(data_out), .xbit_out(xbit_out),
        .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err)
    );

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        wait_ticks(n);
    endtask

    task automatic finish_item(input exp_t it);
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !mon_busy);
        repeat (4) @(posedge clk);
    endtask

    // bad_stop: 0 none, 1 first stop low, 2 second stop low
    task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                              input logic pen, input logic [1:0] pt,
                              input logic xen, input logic xv,
                              input logic sl, input logic mp,
                              input logic flip, input int bad_stop,
                              input string tag);
        int nb;
        logic [7:0] dm;
        logic pexp, ok, done;
        exp_t it;
        nb = 5 + int'(len);
        dm = d & (8'hFF >> (8 - nb));
        unique case (pt)
            2'b00: pexp = ~(^dm);
            2'b01: pexp = ^dm;
            2'b10: pexp = 1'b1;
            default: pexp = 1'b0;
        endcase
        @(negedge clk);
        len_sel = len; par_en = pen; par_type = pt; xbit_en = xen;
        stop_long = sl; mp_en = mp;
        wait_ticks(4);
        drive(1'b0, OSR);
        for (int i = 0; i < nb; i++) drive(dm[i], OSR);
        if (pen) drive(pexp ^ flip, OSR);
        if (xen) drive(xv, OSR);
        if (bad_stop == 1) begin
            drive(1'b0, OSR*3/4); drive(1'b1, OSR/4);
        end else drive(1'b1, OSR);
        if (sl) begin
            if (len == 2'b00) drive(bad_stop == 2 ? 1'b0 : 1'b1, OSR/2);
            else if (bad_stop == 2) begin
                drive(1'b0, OSR*3/4); drive(1'b1, OSR/4);
            end else drive(1'b1, OSR);
        end
        drive(1'b1, 2*OSR);
        ok   = (bad_stop == 0);
        done = ok && (!mp || (xen && xv));
        if (done) begin
            last_data = dm;
            last_xb   = xen & xv;
        end
        it.data = last_data; it.xb = last_xb; it.done = done;
        it.perr = pen & flip; it.ferr = !ok; it.tag = tag;
        finish_item(it);
    endtask

    task automatic send_glitch();
        exp_t it;
        drive(1'b0, 3);
        drive(1'b1, 3*OSR);
        it.data = last_data; it.xb = last_xb; it.done = 1'b0;
        it.perr = 1'b0; it.ferr = 1'b0; it.tag = "R2 noise";
        finish_item(it);
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                mon_busy = 1'b1;
                it = sb_q.pop_front();
                check({it.tag, " data R1"}, data_out, it.data);
                check({it.tag, " xbit R5"}, {7'b0, xbit_out}, {7'b0, it.xb});
                check({it.tag, " done R7"}, {7'b0, rx_done}, {7'b0, it.done});
                check({it.tag, " perr R3"}, {7'b0, par_err}, {7'b0, it.perr});
                check({it.tag, " ferr R6"}, {7'b0, frm_err}, {7'b0, it.ferr});
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
                check({it.tag, " clear R10"}, {5'b0, rx_done, par_err, frm_err}, 8'h00);
                check({it.tag, " clear keeps data R10"}, data_out, it.data);
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("reset R11", {data_out}, 8'h00);
        check("reset flags R11", {4'b0, xbit_out, rx_done, par_err, frm_err}, 8'h00);

        send_frame(8'hA5, 2'b11, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R4 8N1");
        send_frame(8'hFB, 2'b00, 0, 2'b00, 0, 0, 1, 0, 0, 0, "R6 5-bit 1.5 stop");
        send_frame(8'h2D, 2'b01, 1, 2'b01, 0, 0, 0, 0, 0, 0, "R3 6-bit even");
        send_frame(8'h55, 2'b10, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R3 7-bit odd");
        send_frame(8'h3C, 2'b11, 1, 2'b10, 0, 0, 0, 0, 0, 0, "R3 mark");
        send_frame(8'hC3, 2'b11, 1, 2'b11, 0, 0, 0, 0, 0, 0, "R3 space");
        send_frame(8'h96, 2'b11, 1, 2'b00, 0, 0, 0, 0, 1, 0, "R3 parity error");
        send_frame(8'h11, 2'b11, 0, 2'b00, 0, 0, 0, 0, 0, 1, "R9 first stop low");
        send_frame(8'h2A, 2'b01, 0, 2'b00, 0, 0, 1, 0, 0, 2, "R6 second stop low");
        send_frame(8'h0E, 2'b00, 0, 2'b00, 0, 0, 1, 0, 0, 2, "R6 half stop low");
        send_frame(8'h81, 2'b11, 0, 2'b00, 1, 1, 0, 0, 0, 0, "R5 extra bit");
        send_frame(8'h77, 2'b11, 0, 2'b00, 1, 0, 0, 1, 0, 0, "R8 R9 mp suppressed");
        send_frame(8'h42, 2'b11, 1, 2'b01, 1, 1, 1, 1, 0, 0, "R8 mp accepted");
        send_glitch();
        send_frame(8'hFF, 2'b10, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R1 7-bit mask");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule